// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This peripheral measures the rate of one clock picked from a bank of on-chip clock sources. Software selects a source and a gate length in whole microseconds, then starts a run. For that window, a counter that runs on the selected clock counts its rising edges. When the window has closed and the count has come back to the bus clock domain, a busy flag clears and the edge count can be read from a result word. Software turns the count into hertz by scaling it with one million over the gate length in microseconds. The result is accurate to about two counts.

A prescaler divides the bus clock, whose rate in MHz is a parameter, to make the microsecond timebase. The gate is passed into the measured domain through a two-stage synchroniser. The measured domain sends a completion flag back the same way. A source with no clock never raises that flag, so a bounded drain timer ends the run in that case. The edge count stops at its all-ones value, and that value tells software to retry with a shorter gate.

Top module: `freq_meter`

## Requirements
- R1: The control word at byte offset 0x4 reads back the gate code D in bits [15:0], the enable bit at bit 16, the run bit at bit 19, the source index in bits [26:20] and busy in bit 31. Bits 17, 18 and 27 to 30 always read 0, whatever was written to them.
- R2: A write to the control word while idle starts a measurement only if bit 16 and bit 19 are both 1. Busy reads 1 from the cycle after that write. Any other write leaves busy at 0.
- R3: Once started, busy stays high for at least (D+1)×REF_MHZ bus cycles. This is the gate window of D+1 microsecond ticks.
- R4: For a clocked source, the result is the number of rising edges of that source within the gate window, within ±2 counts.
- R5: The result stops at 0xFFFF (result word bits [15:0]) and does not wrap when the source produces more edges than that during the gate.
- R6: Busy falls no more than ACK_TIMEOUT cycles after the gate window ends. If the selected source has no clock, including an index at or above NUM_SRC, the result is 0 and busy falls exactly ACK_TIMEOUT cycles after the gate window ends.
- R7: Writing 0 to the control word aborts any measurement. Busy reads 0 from the next cycle, and the control and result words read 0. A later measurement behaves normally.
- R8: While busy, a nonzero write to the control word is ignored. The fields read back unchanged and the measurement carries on.
- R9: The result word reads 0 from the start of a measurement until it completes. After completion it holds its value, including across a control write that clears the enable bit.
- R10: After reset, all four words read 0.
- R11: The words at byte offsets 0x0 and 0x8 always read 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, REF_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_addr | input | 4 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational and free of side effects |
| src_clks | input | NUM_SRC | Bank of clocks that can be measured |

## Verification
The bench builds the block with NUM_SRC=4, REF_MHZ=2 and ACK_TIMEOUT=16. With four sources, the bench can drive one line that never toggles and can also select an index past the end of the bank, so both no-clock cases are reachable. A two-cycle microsecond keeps the gate short, so a gate long enough to saturate the counter fits in about 24,000 cycles. The short drain limit makes the exact completion time for an idle source a practical thing to check. The behavioural model follows busy on every cycle: it must be high during the gate, may fall during the drain, and must be low once the drain is over.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;
    localparam int DUR_W   = 16;
    localparam int SRC_W   = 7;
    localparam int CNT_W   = 16;
    localparam int WORD_W  = 32;

    localparam logic [3:0] OFS_CTRL   = 4'h4;
    localparam logic [3:0] OFS_RESULT = 4'hC;

    localparam int EN_POS   = 16;
    localparam int RUN_POS  = 19;
    localparam int SRC_POS  = 20;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE  = 2'd1,
        ST_DRAIN = 2'd2
    } fm_state_e;

    typedef struct packed {
        logic [DUR_W-1:0] dur;
        logic             en;
        logic             run;
        logic [SRC_W-1:0] src;
    } fm_ctrl_t;
endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/1ps
module fm_sync (
    input  logic clk,
    input  logic arst,
    input  logic sclr,
    input  logic d,
    output logic q
);
    logic [1:0] stage_d, stage_q;

    always_comb begin
        stage_d = sclr ? 2'b00 : {stage_q[0], d};
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) stage_q <= 2'b00;
        else      stage_q <= stage_d;
    end

    assign q = stage_q[1];
endmodule

// File: rtl/fm_src_mux.sv
`timescale 1ns/1ps
module fm_src_mux #(
    parameter int NUM_SRC = 128,
    parameter int SEL_W   = 7
) (
    input  logic [NUM_SRC-1:0] clks_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               clk_o
);
    always_comb begin
        clk_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_i == SEL_W'(i)) clk_o = clks_i[i];
        end
    end
endmodule

// File: rtl/fm_edge_counter.sv
`timescale 1ns/1ps
module fm_edge_counter
    import fm_pkg::*;
(
    input  logic             mclk,
    input  logic             mrst,
    input  logic             gate_i,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             done;
    } ec_state_t;

    ec_state_t n_d, n_q;
    logic      gate_s;

    fm_sync u_gate_sync (
        .clk  (mclk),
        .arst (mrst),
        .sclr (1'b0),
        .d    (gate_i),
        .q    (gate_s)
    );

    always_comb begin
        n_d = n_q;
        if (gate_s) begin
            n_d.armed = 1'b1;
            if (n_q.cnt != {CNT_W{1'b1}}) n_d.cnt = n_q.cnt + 1'b1;
        end else if (n_q.armed) begin
            n_d.done = 1'b1;
        end
    end

    always_ff @(posedge mclk or posedge mrst) begin
        if (mrst) n_q <= '0;
        else      n_q <= n_d;
    end

    assign count_o = n_q.cnt;
    assign done_o  = n_q.done;
endmodule

// File: rtl/fm_gate_ctrl.sv
`timescale 1ns/1ps
module fm_gate_ctrl
    import fm_pkg::*;
#(
    parameter int REF_MHZ     = 100,
    parameter int ACK_TIMEOUT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              done_i,
    input  logic [CNT_W-1:0]  count_i,
    output fm_ctrl_t          ctrl_o,
    output logic              busy_o,
    output logic              gate_o,
    output logic              mrst_o,
    output logic [CNT_W-1:0]  result_o
);
    localparam int PRE_W = (REF_MHZ > 1) ? $clog2(REF_MHZ) : 1;
    localparam int TO_W  = (ACK_TIMEOUT > 1) ? $clog2(ACK_TIMEOUT) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(REF_MHZ - 1);
    localparam logic [TO_W-1:0]  TO_LAST  = TO_W'(ACK_TIMEOUT - 1);

    typedef struct packed {
        fm_state_e        state;
        fm_ctrl_t         ctrl;
        logic [PRE_W-1:0] presc;
        logic [DUR_W-1:0] ticks;
        logic [TO_W-1:0]  drain;
        logic [CNT_W-1:0] result;
        logic             gate;
        logic             mrst;
    } gc_state_t;

    gc_state_t n_d, n_q;
    logic      start_req;
    logic      abort_req;
    fm_ctrl_t  wr_fields;

    always_comb begin
        wr_fields.dur = wdata_i[DUR_W-1:0];
        wr_fields.en  = wdata_i[EN_POS];
        wr_fields.run = wdata_i[RUN_POS];
        wr_fields.src = wdata_i[SRC_POS +: SRC_W];
    end

    always_comb begin
        n_d       = n_q;
        start_req = wr_ctrl_i && wr_fields.en && wr_fields.run && (n_q.state == ST_IDLE);
        abort_req = wr_ctrl_i && (wdata_i == '0);

        unique case (n_q.state)
            ST_IDLE: begin
                if (wr_ctrl_i) n_d.ctrl = wr_fields;
                if (start_req) begin
                    n_d.state  = ST_GATE;
                    n_d.presc  = '0;
                    n_d.ticks  = wr_fields.dur;
                    n_d.result = '0;
                    n_d.mrst   = 1'b0;
                end
            end
            ST_GATE: begin
                if (n_q.presc == PRE_LAST) begin
                    n_d.presc = '0;
                    if (n_q.ticks == '0) begin
                        n_d.state = ST_DRAIN;
                        n_d.drain = '0;
                    end else begin
                        n_d.ticks = n_q.ticks - 1'b1;
                    end
                end else begin
                    n_d.presc = n_q.presc + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (done_i || (n_q.drain == TO_LAST)) begin
                    n_d.result = count_i;
                    n_d.state  = ST_IDLE;
                    n_d.mrst   = 1'b1;
                end else begin
                    n_d.drain = n_q.drain + 1'b1;
                end
            end
            default: begin
                n_d.state = ST_IDLE;
                n_d.mrst  = 1'b1;
            end
        endcase

        if (abort_req) begin
            n_d.state  = ST_IDLE;
            n_d.ctrl   = '0;
            n_d.result = '0;
            n_d.mrst   = 1'b1;
        end
        n_d.gate = (n_d.state == ST_GATE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q      <= '0;
            n_q.mrst <= 1'b1;
        end else begin
            n_q <= n_d;
        end
    end

    assign ctrl_o   = n_q.ctrl;
    assign busy_o   = (n_q.state != ST_IDLE);
    assign gate_o   = n_q.gate;
    assign mrst_o   = n_q.mrst;
    assign result_o = n_q.result;
endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter
    import fm_pkg::*;
#(
    parameter int NUM_SRC     = 128,
    parameter int REF_MHZ     = 100,
    parameter int ACK_TIMEOUT = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [3:0]         bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_clks
);
    fm_ctrl_t         ctrl_w;
    logic             busy_w;
    logic             gate_w;
    logic             mrst_w;
    logic [CNT_W-1:0] result_w;
    logic [CNT_W-1:0] count_w;
    logic             done_m_w;
    logic             done_s_w;
    logic             sel_clk_w;
    logic             wr_ctrl_w;
    logic             arst_w;

    assign wr_ctrl_w = bus_wr && (bus_addr == OFS_CTRL);
    assign arst_w    = !rst_n;

    fm_gate_ctrl #(
        .REF_MHZ     (REF_MHZ),
        .ACK_TIMEOUT (ACK_TIMEOUT)
    ) u_gate_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (wr_ctrl_w),
        .wdata_i   (bus_wdata),
        .done_i    (done_s_w),
        .count_i   (count_w),
        .ctrl_o    (ctrl_w),
        .busy_o    (busy_w),
        .gate_o    (gate_w),
        .mrst_o    (mrst_w),
        .result_o  (result_w)
    );

    fm_src_mux #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SRC_W)
    ) u_src_mux (
        .clks_i (src_clks),
        .sel_i  (ctrl_w.src),
        .clk_o  (sel_clk_w)
    );

    fm_edge_counter u_edge_cnt (
        .mclk    (sel_clk_w),
        .mrst    (mrst_w),
        .gate_i  (gate_w),
        .count_o (count_w),
        .done_o  (done_m_w)
    );

    fm_sync u_done_sync (
        .clk  (clk),
        .arst (arst_w),
        .sclr (!busy_w),
        .d    (done_m_w),
        .q    (done_s_w)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL:   bus_rdata = {busy_w, 4'b0000, ctrl_w.src, ctrl_w.run,
                                     2'b00, ctrl_w.en, ctrl_w.dur};
            OFS_RESULT: bus_rdata = {{(WORD_W-CNT_W){1'b0}}, result_w};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fm_checker.sv
`timescale 1ns/1ps
module fm_checker #(
    parameter int ACK_TIMEOUT = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        busy,
    input logic        gate,
    input logic [15:0] result,
    input logic [15:0] ctrl_dur,
    input logic [6:0]  ctrl_src
);
    logic wr_ctrl;
    logic wr_zero;
    int   drain_cycles;

    assign wr_ctrl = bus_wr && (bus_addr == 4'h4);
    assign wr_zero = wr_ctrl && (bus_wdata == 32'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             drain_cycles <= 0;
        else if (busy && !gate) drain_cycles <= drain_cycles + 1;
        else                    drain_cycles <= 0;
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[16] && bus_wdata[19] && !busy) |=> busy)
        else $error("R2 start did not raise busy");

    p_gate_then_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate) && !$past(wr_zero)) |-> busy)
        else $error("R3 busy dropped with the gate");

    p_drain_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drain_cycles <= ACK_TIMEOUT)
        else $error("R6 drain exceeded its limit");

    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_zero |=> (!busy && result == 16'd0))
        else $error("R7 abort did not clear");

    p_locked_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_ctrl && bus_wdata != 32'd0) |=> ($stable(ctrl_dur) && $stable(ctrl_src)))
        else $error("R8 fields changed while busy");

    p_result_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> result == 16'd0)
        else $error("R9 result nonzero while busy");
endmodule

bind freq_meter fm_checker #(.ACK_TIMEOUT(ACK_TIMEOUT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy_w),
    .gate      (gate_w),
    .result    (result_w),
    .ctrl_dur  (ctrl_w.dur),
    .ctrl_src  (ctrl_w.src)
);

// File: tb/freq_meter_tb_top.sv
`timescale 1ns/1ps
module freq_meter_tb_top;
    localparam int NSRC = 4;
    localparam int REFM = 2;
    localparam int TOUT = 16;
    localparam real TCLK = 20.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h4;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NSRC-1:0] sclk = '0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // behavioural busy model state
    bit start_req = 0;
    bit abort_req = 0;
    bit nocl_e = 0;
    bit fallen = 0;
    int since = -1;
    int g_exp = 0;

    freq_meter #(.NUM_SRC(NSRC), .REF_MHZ(REFM), .ACK_TIMEOUT(TOUT)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_clks  (sclk)
    );

    always #10 clk = ~clk;
    always #7  sclk[0] = ~sclk[0];
    always #19 sclk[1] = ~sclk[1];
    always #3  sclk[2] = ~sclk[2];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // cycle-by-cycle busy model
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            if (abort_req) begin
                since = -1; abort_req = 0;
            end else if (start_req) begin
                since = 1; start_req = 0; fallen = 0;
            end else if (since > 0) begin
                since++;
            end
            if (bus_addr == 4'h4) begin
                if (since < 0) begin
                    chk(bus_rdata[31] == 1'b0, "R2 busy while idle", bus_rdata[31], 0);
                end else if (since <= g_exp) begin
                    chk(bus_rdata[31] == 1'b1, "R3 busy during gate", bus_rdata[31], 1);
                end else if (since <= g_exp + TOUT) begin
                    if (nocl_e) chk(bus_rdata[31] == 1'b1, "R6 busy in drain, no clock", bus_rdata[31], 1);
                    else        chk(!(fallen && bus_rdata[31]), "R6 busy rose again", bus_rdata[31], 0);
                    if (!bus_rdata[31]) fallen = 1;
                end else begin
                    chk(bus_rdata[31] == 1'b0, "R6 busy after drain limit", bus_rdata[31], 0);
                    since = -1;
                end
            end
        end
    end

    task automatic wr_word(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 4'h4; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
        bus_addr = 4'h4;
    endtask

    function automatic logic [31:0] run_word(input int src, input int dur);
        return (32'(src) << 20) | (32'd1 << 19) | (32'd1 << 16) | 32'(dur);
    endfunction

    task automatic start_meas(input int src, input int dur, input bit nocl);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = run_word(src, dur);
        g_exp = (dur + 1) * REFM; nocl_e = nocl; start_req = 1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 100000; i++) begin
            rd(4'h4, v);
            if (!v[31]) break;
        end
    endtask

    task automatic finish_and_read(input int src, input int dur, output logic [31:0] res);
        wait_idle();
        wr_word(4'h4, run_word(src, dur) & ~(32'd1 << 16));
        rd(4'hC, res);
    endtask

    task automatic measure(input int src, input int dur, input real period, input string req);
        logic [31:0] res;
        real expc;
        longint e;
        start_meas(src, dur, period == 0.0);
        finish_and_read(src, dur, res);
        expc = (period == 0.0) ? 0.0 : (dur + 1) * REFM * TCLK / period;
        if (expc >= 65535.0) begin
            chk(res == 32'h0000_FFFF, req, res, 65535);
        end else begin
            e = longint'(expc);
            chk((longint'(res) >= e - 2) && (longint'(res) <= e + 2) && res[31:16] == 0, req, res, e);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired at %0t", $time);
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] w;
        logic [31:0] held;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R10 reset values
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a), v);
            chk(v == 0, "R10 reset value", v, 0);
        end

        // R1 field layout, reserved bits dropped; enable alone is not a start (R2)
        w = (32'd1 << 20) | (32'd1 << 16) | (32'd1 << 17) | (32'd1 << 18) | (32'd1 << 27) | 32'd9;
        wr_word(4'h4, w);
        rd(4'h4, v);
        chk(v == ((32'd1 << 20) | (32'd1 << 16) | 32'd9), "R1 ctrl readback", v,
            (32'd1 << 20) | (32'd1 << 16) | 32'd9);

        // R2 run without enable: no start
        wr_word(4'h4, (32'd1 << 19) | 32'd5);
        repeat (3) @(negedge clk);
        rd(4'h4, v);
        chk(v == ((32'd1 << 19) | 32'd5), "R2 run alone does not start", v, (32'd1 << 19) | 32'd5);

        // R11 other offsets
        wr_word(4'h0, 32'hFFFF_FFFF);
        wr_word(4'h8, 32'h1234_5678);
        rd(4'h0, v); chk(v == 0, "R11 word 0x0", v, 0);
        rd(4'h8, v); chk(v == 0, "R11 word 0x8", v, 0);
        rd(4'h4, v); chk(v == ((32'd1 << 19) | 32'd5), "R11 ctrl untouched", v, (32'd1 << 19) | 32'd5);

        // R4 accuracy on three clocked sources
        measure(0, 9, 14.0, "R4 src0 count");
        measure(2, 99, 6.0, "R4 src2 count");

        // R8 and R9 during a run on src1
        start_meas(1, 49, 1'b0);
        rd(4'hC, v); chk(v == 0, "R9 result zero while busy", v, 0);
        wr_word(4'h4, 32'h0000_0003);
        rd(4'h4, v);
        chk(v == (run_word(1, 49) | 32'h8000_0000), "R8 write ignored while busy", v,
            run_word(1, 49) | 32'h8000_0000);
        finish_and_read(1, 49, v);
        chk((v >= 50) && (v <= 55), "R4 src1 count", v, 52);
        held = v;
        repeat (5) @(negedge clk);
        rd(4'hC, v); chk(v == held, "R9 result holds", v, held);

        // R6 no-clock sources: idle line and index past the bank
        measure(3, 4, 0.0, "R6 idle line gives zero");
        measure(100, 2, 0.0, "R6 missing index gives zero");

        // R5 saturation
        measure(2, 11999, 6.0, "R5 saturated count");

        // R7 abort mid-run, then recovery
        start_meas(2, 999, 1'b0);
        repeat (100) @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = '0; abort_req = 1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(4'h4, v); chk(v == 0, "R7 ctrl after abort", v, 0);
        rd(4'hC, v); chk(v == 0, "R7 result after abort", v, 0);
        measure(0, 9, 14.0, "R7 measurement after abort");

        repeat (5) @(negedge clk);
        summary();
    end
endmodule